// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle engine that takes a processor into an interrupt service routine and brings it back out. It does not own the architectural registers. It reads the current status word, program counter, stack pointer and the two saved stack pointers through input ports. It changes them only through write-enable/data pairs. All stack and vector-table traffic goes through one memory port that holds each request until the memory answers with a ready strobe.

An entry command carries an 8-bit vector and a 3-bit service level. If the interrupted code was running unprivileged, the sequencer first parks its stack pointer and switches to the privileged stack. It then pushes the old status word and the old program counter, builds the new status word, and fetches the handler address from the vector page. A return command pops the program counter and the status word. If the restored status says unprivileged, the stack pointer is switched back. A return issued while unprivileged is refused and flagged instead.

Top module: `intSequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, privFault and memReq are all 0.
- R2: On entry, if status bit 15 (1 = unprivileged) is set, the saved user stack pointer receives the old stack pointer, and the stack pointer is loaded from the saved supervisor stack pointer before any push; if bit 15 is clear, the saved user stack pointer is not written.
- R3: Each push decrements the stack pointer and then writes at the new value. The old status word goes to SP-1 and the old program counter to SP-2, where SP is the stack pointer after R2. The stack pointer ends at SP-2, with 16-bit wrap-around.
- R4: After the pushes, the status word is rewritten with bit 15 = 0, bits [10:8] = the service level, bits [2:0] = 0, and all other bits unchanged.
- R5: The handler address is read from word address {8'h01, vector}, and the word read becomes the program counter.
- R6: A return in privileged mode reads the program counter from SP, then the status word from SP+1, incrementing the stack pointer after each read.
- R7: After a return, if the restored status bit 15 is 1, the stack pointer is loaded from the saved user stack pointer; otherwise it stays at the incremented value.
- R8: A return requested while status bit 15 is 1 makes no memory access and no register write, keeps busy low, and pulses privFault for exactly one cycle, starting the cycle after the command.
- R9: busy is high from the cycle after an accepted command until the final register load. done is high for exactly one cycle right after that load, with busy low. Commands are accepted only while the block is idle.
- R10: A memory request keeps its address, direction and write data until memReady, and no register is written in a cycle where a request is waiting for ready. An entry therefore writes registers in exactly 5 cycles from unprivileged mode or 4 from privileged mode. A return writes in 3 or 2 cycles.
- R11: If entry and return commands arrive in the same idle cycle, only the entry runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startInt | input | 1 | Begin interrupt entry (one-cycle command) |
| intVector | input | 8 | Vector of the interrupt being serviced |
| intLevel | input | 3 | Service level written into the status word |
| startRti | input | 1 | Begin return from interrupt |
| psrIn | input | 16 | Current processor status word |
| pcIn | input | 16 | Current program counter |
| r6In | input | 16 | Current stack pointer |
| savedUspIn | input | 16 | Saved user stack pointer |
| savedSspIn | input | 16 | Saved supervisor stack pointer |
| memReady | input | 1 | Memory completes the pending access this cycle |
| memRdata | input | 16 | Memory read data |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| psrWe | output | 1 | Status word write enable |
| psrWrData | output | 16 | Status word write data |
| pcWe | output | 1 | Program counter write enable |
| pcWrData | output | 16 | Program counter write data |
| r6We | output | 1 | Stack pointer write enable |
| r6WrData | output | 16 | Stack pointer write data |
| uspWe | output | 1 | Saved user stack pointer write enable |
| uspWrData | output | 16 | Saved user stack pointer write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| privFault | output | 1 | One-cycle privilege-violation pulse |

## Verification
The assertions rely on the register inputs following the write strobes one cycle later. They also expect memReady to rise only while memReq is high, and memRdata to be valid in the same cycle as that ready. The bench meets these assumptions with a register and memory model that commits each write on the clock edge the strobe is seen. That model raises ready after a random wait of zero to two cycles and drives read data on the same edge as ready. Commands are given only from idle, except in directed cases that test that commands during a busy sequence are ignored.

// File: rtl/intSeqPkg.sv
package intSeqPkg;
  localparam int PRIV_BIT = 15;
  localparam int LVL_LO   = 8;
  localparam int CC_W     = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_ESWAP, S_EPSR, S_EPC, S_ESET, S_EVEC,
    S_RPC, S_RPSR, S_RSWAP, S_FIN, S_FAULT
  } seqState_t;

  typedef enum logic [1:0] {ADDR_PUSH, ADDR_POP, ADDR_VEC} addrSel_t;
  typedef enum logic [1:0] {R6_DEC, R6_INC, R6_SSP, R6_USP} r6Sel_t;

  typedef struct packed {
    logic     capEntry;
    logic     capPop;
    logic     memReq;
    logic     memWe;
    addrSel_t addrSel;
    logic     pushPc;
    r6Sel_t   r6Sel;
    logic     r6We;
    logic     uspWe;
    logic     psrWe;
    logic     psrFromMem;
    logic     pcWe;
  } seqStrobe_t;
endpackage

// File: rtl/intSeqCtrl.sv
module intSeqCtrl
  import intSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startInt,
  input  logic       startRti,
  input  logic       curPriv,
  input  logic       snapPriv,
  input  logic       memReady,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       privFault
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    stb.addrSel = ADDR_PUSH;
    stb.r6Sel   = R6_DEC;
    unique case (state)
      S_IDLE: begin
        if (startInt) begin
          stb.capEntry = 1'b1;
          nextState = S_ESWAP;
        end else if (startRti) begin
          nextState = curPriv ? S_FAULT : S_RPC;
        end
      end
      S_ESWAP: begin
        if (snapPriv) begin
          stb.uspWe = 1'b1;
          stb.r6We  = 1'b1;
          stb.r6Sel = R6_SSP;
        end
        nextState = S_EPSR;
      end
      S_EPSR, S_EPC: begin
        stb.memReq  = 1'b1;
        stb.memWe   = 1'b1;
        stb.addrSel = ADDR_PUSH;
        stb.pushPc  = (state == S_EPC);
        if (memReady) begin
          stb.r6We  = 1'b1;
          stb.r6Sel = R6_DEC;
          nextState = (state == S_EPC) ? S_ESET : S_EPC;
        end
      end
      S_ESET: begin
        stb.psrWe = 1'b1;
        nextState = S_EVEC;
      end
      S_EVEC: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADDR_VEC;
        if (memReady) begin
          stb.pcWe  = 1'b1;
          nextState = S_FIN;
        end
      end
      S_RPC: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADDR_POP;
        if (memReady) begin
          stb.pcWe  = 1'b1;
          stb.r6We  = 1'b1;
          stb.r6Sel = R6_INC;
          nextState = S_RPSR;
        end
      end
      S_RPSR: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADDR_POP;
        if (memReady) begin
          stb.psrWe      = 1'b1;
          stb.psrFromMem = 1'b1;
          stb.capPop     = 1'b1;
          stb.r6We       = 1'b1;
          stb.r6Sel      = R6_INC;
          nextState      = S_RSWAP;
        end
      end
      S_RSWAP: begin
        if (snapPriv) begin
          stb.r6We  = 1'b1;
          stb.r6Sel = R6_USP;
        end
        nextState = S_FIN;
      end
      S_FIN:   nextState = S_IDLE;
      S_FAULT: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy      = !(state inside {S_IDLE, S_FIN, S_FAULT});
  assign done      = (state == S_FIN);
  assign privFault = (state == S_FAULT);
endmodule

// File: rtl/intSeqPath.sv
module intSeqPath
  import intSeqPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LVL_W  = 3,
  parameter logic [WORD_W-VEC_W-1:0] VEC_PAGE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [VEC_W-1:0]  intVector,
  input  logic [LVL_W-1:0]  intLevel,
  input  logic [WORD_W-1:0] psrIn,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] r6In,
  input  logic [WORD_W-1:0] savedUspIn,
  input  logic [WORD_W-1:0] savedSspIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic              snapPriv,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              psrWe,
  output logic [WORD_W-1:0] psrWrData,
  output logic              pcWe,
  output logic [WORD_W-1:0] pcWrData,
  output logic              r6We,
  output logic [WORD_W-1:0] r6WrData,
  output logic              uspWe,
  output logic [WORD_W-1:0] uspWrData
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] snapPsr, snapPc, entryPsr, spDown, spUp;
  logic [VEC_W-1:0]  vecReg;
  logic [LVL_W-1:0]  lvlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapPsr <= '0;
      snapPc  <= '0;
      vecReg  <= '0;
      lvlReg  <= '0;
    end else if (stb.capEntry) begin
      snapPsr <= psrIn;
      snapPc  <= pcIn;
      vecReg  <= intVector;
      lvlReg  <= intLevel;
    end else if (stb.capPop) begin
      snapPsr <= memRdata;
    end
  end

  assign snapPriv = snapPsr[PRIV_BIT];
  assign spDown   = r6In - ONE;
  assign spUp     = r6In + ONE;

  always_comb begin
    entryPsr = snapPsr;
    entryPsr[PRIV_BIT] = 1'b0;
    entryPsr[LVL_LO +: LVL_W] = lvlReg;
    entryPsr[CC_W-1:0] = '0;
  end

  always_comb begin
    unique case (stb.addrSel)
      ADDR_PUSH: memAddr = spDown;
      ADDR_POP:  memAddr = r6In;
      default:   memAddr = {VEC_PAGE, vecReg};
    endcase
  end

  always_comb begin
    unique case (stb.r6Sel)
      R6_DEC:  r6WrData = spDown;
      R6_INC:  r6WrData = spUp;
      R6_SSP:  r6WrData = savedSspIn;
      default: r6WrData = savedUspIn;
    endcase
  end

  assign memReq    = stb.memReq;
  assign memWe     = stb.memWe;
  assign memWdata  = stb.pushPc ? snapPc : snapPsr;
  assign psrWe     = stb.psrWe;
  assign psrWrData = stb.psrFromMem ? memRdata : entryPsr;
  assign pcWe      = stb.pcWe;
  assign pcWrData  = memRdata;
  assign r6We      = stb.r6We;
  assign uspWe     = stb.uspWe;
  assign uspWrData = r6In;
endmodule

// File: rtl/intSequencer.sv
module intSequencer
  import intSeqPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startInt,
  input  logic [VEC_W-1:0]  intVector,
  input  logic [LVL_W-1:0]  intLevel,
  input  logic              startRti,
  input  logic [WORD_W-1:0] psrIn,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [WORD_W-1:0] r6In,
  input  logic [WORD_W-1:0] savedUspIn,
  input  logic [WORD_W-1:0] savedSspIn,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              psrWe,
  output logic [WORD_W-1:0] psrWrData,
  output logic              pcWe,
  output logic [WORD_W-1:0] pcWrData,
  output logic              r6We,
  output logic [WORD_W-1:0] r6WrData,
  output logic              uspWe,
  output logic [WORD_W-1:0] uspWrData,
  output logic              busy,
  output logic              done,
  output logic              privFault
);
  seqStrobe_t stb;
  logic snapPriv;

  intSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startInt(startInt), .startRti(startRti),
    .curPriv(psrIn[PRIV_BIT]), .snapPriv(snapPriv), .memReady(memReady),
    .stb(stb), .busy(busy), .done(done), .privFault(privFault)
  );

  intSeqPath #(.WORD_W(WORD_W), .VEC_W(VEC_W), .LVL_W(LVL_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .intVector(intVector), .intLevel(intLevel),
    .psrIn(psrIn), .pcIn(pcIn), .r6In(r6In), .savedUspIn(savedUspIn),
    .savedSspIn(savedSspIn), .memRdata(memRdata), .snapPriv(snapPriv),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .psrWe(psrWe), .psrWrData(psrWrData), .pcWe(pcWe), .pcWrData(pcWrData),
    .r6We(r6We), .r6WrData(r6WrData), .uspWe(uspWe), .uspWrData(uspWrData)
  );
endmodule

// File: rtl/intSeqChecker.sv
module intSeqChecker #(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [WORD_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              psrWe,
  input logic [WORD_W-1:0] psrWrData,
  input logic              pcWe,
  input logic              r6We,
  input logic [WORD_W-1:0] r6WrData,
  input logic              uspWe,
  input logic              busy,
  input logic              done,
  input logic              privFault
);
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_no_early_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |-> !psrWe && !pcWe && !r6We && !uspWe);

  p_push_moves_sp_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |-> r6We && r6WrData == memAddr);

  p_entry_psr_r4: assert property (@(posedge clk) disable iff (!rstN)
    psrWe && !memReq |-> psrWrData[15] == 1'b0 && psrWrData[2:0] == 3'b000);

  p_vec_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    pcWe && !r6We |-> memAddr[WORD_W-1:VEC_W] == 1);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> !memReq && !psrWe && !pcWe && !r6We && !uspWe && !busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind intSequencer intSeqChecker #(.WORD_W(WORD_W), .VEC_W(VEC_W)) uChk (.*);

// File: tb/sim_intSequencer.sv
module sim_intSequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, startInt, startRti, memReady;
  logic [7:0]  intVector;
  logic [2:0]  intLevel;
  logic [15:0] memRdata;
  logic [15:0] psr, pc, r6, usp, ssp;
  logic memReq, memWe, psrWe, pcWe, r6We, uspWe, busy, done, privFault;
  logic [15:0] memAddr, memWdata, psrWrData, pcWrData, r6WrData, uspWrData;

  intSequencer u0 (
    .clk(clk), .rstN(rstN), .startInt(startInt), .intVector(intVector),
    .intLevel(intLevel), .startRti(startRti), .psrIn(psr), .pcIn(pc), .r6In(r6),
    .savedUspIn(usp), .savedSspIn(ssp), .memReady(memReady), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .psrWe(psrWe), .psrWrData(psrWrData), .pcWe(pcWe), .pcWrData(pcWrData),
    .r6We(r6We), .r6WrData(r6WrData), .uspWe(uspWe), .uspWrData(uspWrData),
    .busy(busy), .done(done), .privFault(privFault)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int memCycles = 0, wrCycles = 0, waitLeft = 0;
  logic [15:0] mem [logic [15:0]];

  function automatic logic [15:0] rdMem(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] entryPsr(logic [15:0] p, logic [2:0] l);
    logic [15:0] n = p;
    n[15] = 1'b0; n[10:8] = l; n[2:0] = 3'b000;
    return n;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // register file and memory model: writes commit on the edge the strobe is seen
  always @(posedge clk) begin
    if (rstN) begin
      if (memReq) memCycles++;
      if (psrWe || pcWe || r6We || uspWe) wrCycles++;
      if (memReq && memWe && memReady) mem[memAddr] = memWdata;
      if (psrWe) psr <= psrWrData;
      if (pcWe)  pc  <= pcWrData;
      if (r6We)  r6  <= r6WrData;
      if (uspWe) usp <= uspWrData;
    end
  end

  always @(negedge clk) begin
    if (memReady) begin
      memReady <= 1'b0;
      waitLeft = $urandom % 3;
    end else if (memReq) begin
      if (waitLeft == 0) begin
        memReady <= 1'b1;
        memRdata <= rdMem(memAddr);
      end else waitLeft--;
    end
  end

  task automatic waitDone(string req);
    int n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, "done seen", 16'(done), 16'h1);
  endtask

  // noise: 1 = poke commands during busy (R9), 2 = both commands together (R11)
  task automatic doEntry(logic [7:0] v, logic [2:0] l, int noise);
    logic [15:0] oPsr = psr, oPc = pc, oR6 = r6, oUsp = usp, sp;
    int w0 = wrCycles;
    sp = oPsr[15] ? ssp : oR6;
    @(negedge clk);
    startInt = 1; intVector = v; intLevel = l; startRti = (noise == 2);
    @(negedge clk);
    startInt = 0; startRti = 0;
    chk(busy == 1'b1, "R9", "busy after entry cmd", 16'(busy), 16'h1);
    if (noise == 1) begin
      @(negedge clk);
      startInt = 1; startRti = 1; intVector = ~v; intLevel = ~l;
      @(negedge clk);
      startInt = 0; startRti = 0;
    end
    waitDone("R9");
    chk(busy == 1'b0, "R9", "busy low at done", 16'(busy), 16'h0);
    chk(usp == (oPsr[15] ? oR6 : oUsp), "R2", "saved user sp", usp, oPsr[15] ? oR6 : oUsp);
    chk(rdMem(sp - 16'd1) == oPsr, "R3", "pushed status", rdMem(sp - 16'd1), oPsr);
    chk(rdMem(sp - 16'd2) == oPc, "R3", "pushed pc", rdMem(sp - 16'd2), oPc);
    chk(r6 == sp - 16'd2, "R3", "sp after entry", r6, sp - 16'd2);
    chk(psr == entryPsr(oPsr, l), "R4", "entry status", psr, entryPsr(oPsr, l));
    chk(pc == rdMem({8'h01, v}), "R5", "handler pc", pc, rdMem({8'h01, v}));
    chk(wrCycles - w0 == (oPsr[15] ? 5 : 4), "R10", "write cycles entry",
        16'(wrCycles - w0), oPsr[15] ? 16'd5 : 16'd4);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single pulse", 16'(done), 16'h0);
  endtask

  task automatic doRti();
    logic [15:0] oPsr = psr, oPc = pc, oR6 = r6, oUsp = usp, nPc, nPsr, eR6;
    int w0 = wrCycles, m0 = memCycles;
    @(negedge clk);
    startRti = 1;
    @(negedge clk);
    startRti = 0;
    if (oPsr[15]) begin
      chk(privFault == 1'b1, "R8", "fault pulse", 16'(privFault), 16'h1);
      chk(busy == 1'b0, "R8", "busy during fault", 16'(busy), 16'h0);
      repeat (3) @(negedge clk);
      chk(privFault == 1'b0, "R8", "fault single", 16'(privFault), 16'h0);
      chk(memCycles == m0 && wrCycles == w0, "R8", "no access",
          16'(memCycles - m0 + wrCycles - w0), 16'h0);
      chk(psr == oPsr && pc == oPc && r6 == oR6, "R8", "regs kept", pc, oPc);
    end else begin
      nPc = rdMem(oR6); nPsr = rdMem(oR6 + 16'd1);
      eR6 = nPsr[15] ? oUsp : oR6 + 16'd2;
      chk(busy == 1'b1, "R9", "busy after rti cmd", 16'(busy), 16'h1);
      waitDone("R9");
      chk(pc == nPc, "R6", "popped pc", pc, nPc);
      chk(psr == nPsr, "R6", "popped status", psr, nPsr);
      chk(r6 == eR6, "R7", "sp after return", r6, eR6);
      chk(wrCycles - w0 == (nPsr[15] ? 3 : 2), "R10", "write cycles rti",
          16'(wrCycles - w0), nPsr[15] ? 16'd3 : 16'd2);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] kPsr, kPc, kR6;
    int depth = 0;
    void'($urandom(32'd4242));
    rstN = 0; startInt = 0; startRti = 0; intVector = 0; intLevel = 0;
    memReady = 0; memRdata = 0;
    psr = 16'h8002; pc = 16'h3006; r6 = 16'h5000; usp = 16'h0000; ssp = 16'h3000;
    for (int v = 0; v < 256; v++) mem[{8'h01, 8'(v)}] = 16'h6000 + 16'(v * 3);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !privFault && !memReq, "R1", "in reset", 16'(busy), 16'h0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done && !privFault && !memReq, "R1", "after reset", 16'(memReq), 16'h0);

    // R8: return while unprivileged is refused
    doRti();
    // R2 R7: round trip from user code restores everything
    kPsr = psr; kPc = pc; kR6 = r6;
    doEntry(8'h80, 3'd4, 0);
    doRti();
    chk(psr == kPsr && pc == kPc, "R7", "round trip status/pc", psr, kPsr);
    chk(r6 == kR6, "R7", "round trip sp", r6, kR6);
    // R9: commands during busy are ignored; R11: entry wins over return
    doEntry(8'h00, 3'd1, 1);
    doEntry(8'hFF, 3'd7, 2);
    doRti(); doRti();
    // R3: stack wraps below address zero
    psr = 16'h8707; pc = 16'h1234; r6 = 16'h7777; ssp = 16'h0001;
    @(negedge clk);
    doEntry(8'h21, 3'd6, 0);
    doRti();
    chk(r6 == 16'h7777, "R7", "wrap round trip sp", r6, 16'h7777);
    ssp = 16'h3000;

    // constrained random nesting
    for (int i = 0; i < 60; i++) begin
      if (depth == 0 || (depth < 6 && ($urandom % 2) == 0)) begin
        if (depth == 0) begin
          psr = 16'($urandom); pc = 16'($urandom);
          r6 = 16'h4000 + 16'($urandom % 16'h0800);
          if (!psr[15]) r6 = 16'h2800 + 16'($urandom % 16'h0400);
        end else begin
          psr[2:0] = 3'($urandom); pc = 16'($urandom);
        end
        @(negedge clk);
        doEntry(8'($urandom), 3'($urandom), 0);
        depth++;
      end else begin
        doRti();
        depth--;
      end
    end
    while (depth > 0) begin doRti(); depth--; end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule